// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the central state machine of a multicycle RISC-V style core that owns a single shared instruction/data memory and a single ALU. Each instruction is broken into a short series of clock cycles. In every cycle the controller selects the memory address source, enables the instruction register, picks the ALU operands and operation class, selects the result bus and raises the write enables for the register file, the memory and the program counter.

The ALU does double duty. During the fetch cycle it forms PC+4. During the decode cycle it forms the old PC plus the immediate, so that a branch or jump target is ready before the execute cycle. The controller takes only the 7-bit opcode and the ALU zero flag as inputs. The ALU decoder, the immediate extender and the datapath registers sit outside it. The present state is brought out so that its path through the states can be observed.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `state_o` is 0 (fetch). Reset may be applied in the middle of an instruction and still returns the state to 0.
- R2: In fetch (state 0) the outputs are: `adr_sel_o`=0 (PC), `ir_we_o`=1, `alu_a_sel_o`=0 (PC), `alu_b_sel_o`=2 (constant 4), `alu_op_o`=0 (add), `res_sel_o`=2 (ALU result), `pc_upd_o`=1. All other enables are 0.
- R3: Fetch is always followed by decode (state 1). Decode drives `alu_a_sel_o`=1 (old PC), `alu_b_sel_o`=1 (immediate), `alu_op_o`=0, with every write enable at 0.
- R4: A load (opcode 0000011) passes through states 0,1,2,3,4, which is 5 cycles. State 2 uses `alu_a_sel_o`=2 (register), `alu_b_sel_o`=1 and `alu_op_o`=0. State 3 sets `adr_sel_o`=1 and `res_sel_o`=0 (registered ALU output). State 4 sets `reg_we_o`=1 and `res_sel_o`=1 (memory data).
- R5: A store (opcode 0100011) passes through states 0,1,2,5, which is 4 cycles. State 5 sets `adr_sel_o`=1 and `mem_we_o`=1 and keeps `reg_we_o` at 0.
- R6: A register-register ALU instruction (opcode 0110011) passes through states 0,1,6,7. State 6 uses `alu_a_sel_o`=2, `alu_b_sel_o`=0 (register) and `alu_op_o`=2 (function-field decoded). State 7 sets `reg_we_o`=1 and `res_sel_o`=0.
- R7: A register-immediate ALU instruction (opcode 0010011) passes through states 0,1,8,7. State 8 uses `alu_a_sel_o`=2, `alu_b_sel_o`=1 and `alu_op_o`=2.
- R8: A jump-and-link (opcode 1101111) passes through states 0,1,9,7. State 9 uses `alu_a_sel_o`=1, `alu_b_sel_o`=2, `alu_op_o`=0 and `res_sel_o`=0, and sets `pc_upd_o`=1. The write of the link value to rd happens in state 7.
- R9: A branch-if-equal (opcode 1100011) passes through states 0,1,10, which is 3 cycles. State 10 uses `alu_a_sel_o`=2, `alu_b_sel_o`=0, `alu_op_o`=1 (subtract) and `res_sel_o`=0, and sets `branch_o`=1. `pc_we_o` is 1 in that state only when `zero_i` is 1.
- R10: Any other opcode seen in decode returns the machine to fetch on the next cycle. No register write and no memory write occur in between.
- R11: `pc_we_o` is high exactly when `pc_upd_o` is high, or when both `branch_o` and `zero_i` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 7 | Opcode field of the held instruction |
| zero_i | input | 1 | ALU zero flag |
| adr_sel_o | output | 1 | Memory address source: 0 PC, 1 registered ALU output |
| ir_we_o | output | 1 | Instruction register write enable |
| pc_upd_o | output | 1 | Unconditional PC update request |
| branch_o | output | 1 | Conditional PC update request |
| reg_we_o | output | 1 | Register file write enable |
| mem_we_o | output | 1 | Memory write enable |
| alu_a_sel_o | output | 2 | ALU A source: 0 PC, 1 old PC, 2 register rs1 |
| alu_b_sel_o | output | 2 | ALU B source: 0 register rs2, 1 immediate, 2 constant 4 |
| alu_op_o | output | 2 | ALU class: 0 add, 1 subtract, 2 function-field decoded |
| res_sel_o | output | 2 | Result bus: 0 ALU output register, 1 memory data, 2 ALU result |
| pc_we_o | output | 1 | Gated PC write enable |
| state_o | output | 4 | Present state number, 0 to 10 |

## Verification
The block has no width parameters beyond the fixed package constants, so the bench builds it as delivered. Directed scenarios walk every opcode path cycle by cycle. Each visited state is compared, together with the complete control vector, against a table derived from the requirements, which also confirms the 3, 4 and 5 cycle counts. The branch is run with the zero flag both high and low to exercise the PC gate. Further scenarios cover an unknown opcode, back-to-back instructions, and a reset applied mid-load.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;
  localparam int OP_W  = 7;
  localparam int ST_W  = 4;
  localparam int SEL_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MEMADR = 4'd2,
    ST_MEMRD  = 4'd3,
    ST_MEMWB  = 4'd4,
    ST_MEMWR  = 4'd5,
    ST_EXE_R  = 4'd6,
    ST_ALUWB  = 4'd7,
    ST_EXE_I  = 4'd8,
    ST_JAL    = 4'd9,
    ST_BEQ    = 4'd10
  } state_e;

  localparam logic [OP_W-1:0] OP_LOAD  = 7'b0000011;
  localparam logic [OP_W-1:0] OP_STORE = 7'b0100011;
  localparam logic [OP_W-1:0] OP_ALU_R = 7'b0110011;
  localparam logic [OP_W-1:0] OP_ALU_I = 7'b0010011;
  localparam logic [OP_W-1:0] OP_JAL   = 7'b1101111;
  localparam logic [OP_W-1:0] OP_BEQ   = 7'b1100011;

  localparam logic [SEL_W-1:0] A_PC = 2'd0, A_OLDPC = 2'd1, A_REG = 2'd2;
  localparam logic [SEL_W-1:0] B_REG = 2'd0, B_IMM = 2'd1, B_FOUR = 2'd2;
  localparam logic [SEL_W-1:0] OPC_ADD = 2'd0, OPC_SUB = 2'd1, OPC_FN = 2'd2;
  localparam logic [SEL_W-1:0] R_ALUOUT = 2'd0, R_DATA = 2'd1, R_ALURES = 2'd2;

  typedef struct packed {
    logic             adr_sel;
    logic             ir_we;
    logic             pc_upd;
    logic             branch;
    logic             reg_we;
    logic             mem_we;
    logic [SEL_W-1:0] a_sel;
    logic [SEL_W-1:0] b_sel;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] res_sel;
  } ctrl_t;
endpackage

// File: rtl/mc_seq_next.sv
module mc_seq_next
  import mc_seq_pkg::*;
(
  input  state_e          state_i,
  input  logic [OP_W-1:0] opcode_i,
  output state_e          next_o
);
  always_comb begin
    next_o = ST_FETCH;
    unique case (state_i)
      ST_FETCH:  next_o = ST_DECODE;
      ST_DECODE: begin
        unique case (opcode_i)
          OP_LOAD, OP_STORE: next_o = ST_MEMADR;
          OP_ALU_R:          next_o = ST_EXE_R;
          OP_ALU_I:          next_o = ST_EXE_I;
          OP_JAL:            next_o = ST_JAL;
          OP_BEQ:            next_o = ST_BEQ;
          default:           next_o = ST_FETCH; // unknown: abandon quietly
        endcase
      end
      ST_MEMADR: next_o = (opcode_i == OP_LOAD) ? ST_MEMRD : ST_MEMWR;
      ST_MEMRD:  next_o = ST_MEMWB;
      ST_EXE_R,
      ST_EXE_I,
      ST_JAL:    next_o = ST_ALUWB;
      default:   next_o = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_seq_out.sv
module mc_seq_out
  import mc_seq_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.ir_we   = 1'b1;
        ctrl_o.pc_upd  = 1'b1;
        ctrl_o.a_sel   = A_PC;
        ctrl_o.b_sel   = B_FOUR;
        ctrl_o.alu_op  = OPC_ADD;
        ctrl_o.res_sel = R_ALURES;
      end
      ST_DECODE: begin
        ctrl_o.a_sel  = A_OLDPC;
        ctrl_o.b_sel  = B_IMM;
        ctrl_o.alu_op = OPC_ADD;
      end
      ST_MEMADR: begin
        ctrl_o.a_sel  = A_REG;
        ctrl_o.b_sel  = B_IMM;
        ctrl_o.alu_op = OPC_ADD;
      end
      ST_MEMRD: begin
        ctrl_o.adr_sel = 1'b1;
        ctrl_o.res_sel = R_ALUOUT;
      end
      ST_MEMWB: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.res_sel = R_DATA;
      end
      ST_MEMWR: begin
        ctrl_o.adr_sel = 1'b1;
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.res_sel = R_ALUOUT;
      end
      ST_EXE_R: begin
        ctrl_o.a_sel  = A_REG;
        ctrl_o.b_sel  = B_REG;
        ctrl_o.alu_op = OPC_FN;
      end
      ST_ALUWB: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.res_sel = R_ALUOUT;
      end
      ST_EXE_I: begin
        ctrl_o.a_sel  = A_REG;
        ctrl_o.b_sel  = B_IMM;
        ctrl_o.alu_op = OPC_FN;
      end
      ST_JAL: begin
        ctrl_o.pc_upd  = 1'b1;
        ctrl_o.a_sel   = A_OLDPC;
        ctrl_o.b_sel   = B_FOUR;
        ctrl_o.alu_op  = OPC_ADD;
        ctrl_o.res_sel = R_ALUOUT;
      end
      ST_BEQ: begin
        ctrl_o.branch  = 1'b1;
        ctrl_o.a_sel   = A_REG;
        ctrl_o.b_sel   = B_REG;
        ctrl_o.alu_op  = OPC_SUB;
        ctrl_o.res_sel = R_ALUOUT;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_pc_gate.sv
module mc_pc_gate (
  input  logic pc_upd_i,
  input  logic branch_i,
  input  logic zero_i,
  output logic pc_we_o
);
  assign pc_we_o = pc_upd_i | (branch_i & zero_i);
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic             zero_i,
  output logic             adr_sel_o,
  output logic             ir_we_o,
  output logic             pc_upd_o,
  output logic             branch_o,
  output logic             reg_we_o,
  output logic             mem_we_o,
  output logic [SEL_W-1:0] alu_a_sel_o,
  output logic [SEL_W-1:0] alu_b_sel_o,
  output logic [SEL_W-1:0] alu_op_o,
  output logic [SEL_W-1:0] res_sel_o,
  output logic             pc_we_o,
  output logic [ST_W-1:0]  state_o
);
  state_e state_q, state_d;
  ctrl_t  ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  mc_seq_next u_next (
    .state_i  (state_q),
    .opcode_i (opcode_i),
    .next_o   (state_d)
  );

  mc_seq_out u_out (
    .state_i (state_q),
    .ctrl_o  (ctrl)
  );

  mc_pc_gate u_gate (
    .pc_upd_i (ctrl.pc_upd),
    .branch_i (ctrl.branch),
    .zero_i   (zero_i),
    .pc_we_o  (pc_we_o)
  );

  assign adr_sel_o   = ctrl.adr_sel;
  assign ir_we_o     = ctrl.ir_we;
  assign pc_upd_o    = ctrl.pc_upd;
  assign branch_o    = ctrl.branch;
  assign reg_we_o    = ctrl.reg_we;
  assign mem_we_o    = ctrl.mem_we;
  assign alu_a_sel_o = ctrl.a_sel;
  assign alu_b_sel_o = ctrl.b_sel;
  assign alu_op_o    = ctrl.alu_op;
  assign res_sel_o   = ctrl.res_sel;
  assign state_o     = state_q;
endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk
  import mc_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OP_W-1:0]  opcode_i,
  input logic             zero_i,
  input logic             adr_sel_o,
  input logic             ir_we_o,
  input logic             pc_upd_o,
  input logic             branch_o,
  input logic             reg_we_o,
  input logic             mem_we_o,
  input logic [SEL_W-1:0] alu_op_o,
  input logic             pc_we_o,
  input logic [ST_W-1:0]  state_o
);
  logic op_known;
  assign op_known = opcode_i inside {OP_LOAD, OP_STORE, OP_ALU_R, OP_ALU_I, OP_JAL, OP_BEQ};

  AST_FETCH_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'd0 |-> ir_we_o && pc_upd_o && !adr_sel_o && !reg_we_o && !mem_we_o); // R2
  AST_DECODE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'd0 |=> state_o == 4'd1); // R3
  AST_STORE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> adr_sel_o && !reg_we_o); // R5
  AST_BEQ_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o |-> alu_op_o == 2'd1 && !reg_we_o); // R9
  AST_UNKNOWN_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'd1 && !op_known |=> state_o == 4'd0 && !reg_we_o && !mem_we_o); // R10
  AST_PC_GATE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_upd_o || (branch_o && zero_i)) |-> pc_we_o); // R11
  AST_PC_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> pc_upd_o || (branch_o && zero_i)); // R11
  AST_STATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 4'd10); // R1
endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .opcode_i  (opcode_i),
  .zero_i    (zero_i),
  .adr_sel_o (adr_sel_o),
  .ir_we_o   (ir_we_o),
  .pc_upd_o  (pc_upd_o),
  .branch_o  (branch_o),
  .reg_we_o  (reg_we_o),
  .mem_we_o  (mem_we_o),
  .alu_op_o  (alu_op_o),
  .pc_we_o   (pc_we_o),
  .state_o   (state_o)
);

// File: tb/mc_seq_ctrl_tb.sv
module mc_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] opcode_i = 7'd0;
  logic       zero_i = 1'b0;
  logic       adr_sel_o, ir_we_o, pc_upd_o, branch_o, reg_we_o, mem_we_o, pc_we_o;
  logic [1:0] alu_a_sel_o, alu_b_sel_o, alu_op_o, res_sel_o;
  logic [3:0] state_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mc_seq_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i), .zero_i(zero_i),
    .adr_sel_o(adr_sel_o), .ir_we_o(ir_we_o), .pc_upd_o(pc_upd_o),
    .branch_o(branch_o), .reg_we_o(reg_we_o), .mem_we_o(mem_we_o),
    .alu_a_sel_o(alu_a_sel_o), .alu_b_sel_o(alu_b_sel_o), .alu_op_o(alu_op_o),
    .res_sel_o(res_sel_o), .pc_we_o(pc_we_o), .state_o(state_o)
  );

  // {adr, ir, pcu, br, rw, mw, a, b, op, res, pcwe}
  function automatic logic [14:0] exp_ctrl(int st, logic z);
    case (st)
      0:  return {6'b011000, 2'd0, 2'd2, 2'd0, 2'd2, 1'b1};
      1:  return {6'b000000, 2'd1, 2'd1, 2'd0, 2'd0, 1'b0};
      2:  return {6'b000000, 2'd2, 2'd1, 2'd0, 2'd0, 1'b0};
      3:  return {6'b100000, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0};
      4:  return {6'b000010, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0};
      5:  return {6'b100001, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0};
      6:  return {6'b000000, 2'd2, 2'd0, 2'd2, 2'd0, 1'b0};
      7:  return {6'b000010, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0};
      8:  return {6'b000000, 2'd2, 2'd1, 2'd2, 2'd0, 1'b0};
      9:  return {6'b001000, 2'd1, 2'd2, 2'd0, 2'd0, 1'b1};
      10: return {6'b000100, 2'd2, 2'd0, 2'd1, 2'd0, z};
      default: return '0;
    endcase
  endfunction

  function automatic logic [14:0] act_ctrl();
    return {adr_sel_o, ir_we_o, pc_upd_o, branch_o, reg_we_o, mem_we_o,
            alu_a_sel_o, alu_b_sel_o, alu_op_o, res_sel_o, pc_we_o};
  endfunction

  task automatic check_now(string tag, int st);
    n_chk++;
    if (state_o !== st[3:0] || act_ctrl() !== exp_ctrl(st, zero_i)) begin
      n_fail++;
      $display("FAIL %s: state=%0d ctrl=%b expected state=%0d ctrl=%b",
               tag, state_o, act_ctrl(), st, exp_ctrl(st, zero_i));
    end
  endtask

  // check present cycle, then move past the next rising edge
  task automatic step(string tag, int st);
    check_now(tag, st);
    @(posedge clk_i); #2;
  endtask

  task automatic run_path(string tag, logic [6:0] op, logic z, int p[]);
    opcode_i = op;
    zero_i   = z;
    foreach (p[i]) step(tag, p[i]);
    check_now({tag, " back to fetch"}, 0);
  endtask

  task automatic t_reset();
    #3 check_now("R1 in reset", 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #2;
    check_now("R1 R3 first cycle after reset", 1);
    @(posedge clk_i); #2; // unknown opcode 0 -> fetch
    check_now("R2 fetch after reset", 0);
  endtask

  task automatic t_load();    run_path("R4 load",    7'b0000011, 1'b0, '{0,1,2,3,4}); endtask
  task automatic t_store();   run_path("R5 store",   7'b0100011, 1'b0, '{0,1,2,5}); endtask
  task automatic t_alu_r();   run_path("R6 alu reg", 7'b0110011, 1'b1, '{0,1,6,7}); endtask
  task automatic t_alu_i();   run_path("R7 alu imm", 7'b0010011, 1'b0, '{0,1,8,7}); endtask
  task automatic t_jal();     run_path("R8 jal",     7'b1101111, 1'b0, '{0,1,9,7}); endtask
  task automatic t_beq_tk();  run_path("R9 R11 beq taken",     7'b1100011, 1'b1, '{0,1,10}); endtask
  task automatic t_beq_nt();  run_path("R9 R11 beq not taken", 7'b1100011, 1'b0, '{0,1,10}); endtask
  task automatic t_unknown(); run_path("R10 unknown opcode",   7'b1111111, 1'b1, '{0,1}); endtask

  task automatic t_reset_mid();
    opcode_i = 7'b0000011;
    step("R1 load before reset", 0);
    step("R1 load before reset", 1);
    check_now("R1 load address", 2);
    #1 rst_ni = 1'b0;
    #1 check_now("R1 reset mid-load", 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #2;
    check_now("R1 decode after mid reset", 1);
    @(posedge clk_i); #2;
    check_now("R1 address after mid reset", 2);
    @(posedge clk_i); #2;
    @(posedge clk_i); #2;
    @(posedge clk_i); #2;
    check_now("R1 fetch after finishing load", 0);
  endtask

  initial begin
    t_reset();
    t_load();
    t_store();
    t_alu_r();
    t_alu_i();
    t_jal();
    t_beq_tk();
    t_beq_nt();
    t_unknown();
    t_load();
    t_beq_tk();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule